// File: doc/BRIEF.md
# Priority Interrupt Bus Arbiter

This block decides which device on a shared system bus may interrupt the processor. There are four request groups. Each group serves a chain of devices that share one request level. A request on group `L` carries priority `L + 4`. It is taken only if that priority is strictly above the processor's current level. Otherwise it waits. When several groups request at once, the highest-numbered group wins. Inside a group, the device nearest the arbiter wins. The arbiter models the chain internally, so exactly one device grant goes out.

Grants are issued only at the instruction-boundary strobe. A granted device answers with a vector-valid strobe and the vector value. The arbiter then registers the vector, pulses the take-interrupt output for the processor's trap sequence, and withdraws the grant. It issues no further grant until the served device has dropped its request. If no answer arrives within a fixed number of cycles, the arbiter withdraws the grant and pulses a no-response flag.

Top module: `irq_bus_arbiter`

## Requirements
- R1: While reset is high, and in the first cycle after it, all device grants, `take_o`, `norsp_o` and `vec_o` are zero.
- R2: A request on group L has priority L+4. It is granted only if L+4 is strictly greater than `cpu_pri_i`. Otherwise no grant is issued and the request stays pending until the level drops.
- R3: When several groups request together, the grant goes to a device in the highest-numbered requesting group.
- R4: Device d of group L sits on `dev_req_i`/`dev_gnt_o` bit L*DEVS+d, and d=0 is nearest the arbiter. Among the requesters of the winning group, the one with the lowest d is granted.
- R5: A new grant is taken only in a cycle where `insn_end_i` is sampled high while idle. The grant is visible from the following cycle. While `insn_end_i` stays low, no grant is issued.
- R6: A grant stays asserted until `vec_valid_i` is sampled high. At that edge `vec_i` is registered onto `vec_o`, `take_o` is high for exactly the next cycle, and the grant drops in that same cycle.
- R7: After a device is served, no new grant is issued while that device keeps its request asserted. Once it drops its request, other pending requests are arbitrated again.
- R8: If a grant sees no `vec_valid_i` for TIMEOUT_CYC cycles, it is withdrawn after exactly TIMEOUT_CYC cycles and `norsp_o` pulses for one cycle. `norsp_o` and `take_o` are never high together.
- R9: At most one device grant is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req_i | input | LINES*DEVS | Per-device request, bit L*DEVS+d |
| cpu_pri_i | input | PRI_W | Processor's current priority level |
| insn_end_i | input | 1 | Instruction boundary strobe |
| dev_gnt_o | output | LINES*DEVS | Per-device grant, one-hot or zero |
| vec_valid_i | input | 1 | Granted device presents its vector |
| vec_i | input | VEC_W | Vector address from the device |
| take_o | output | 1 | One-cycle pulse: processor takes the interrupt |
| vec_o | output | VEC_W | Registered vector for the processor |
| norsp_o | output | 1 | One-cycle pulse: grant timed out unanswered |

## Verification
The hardest situation to reach from the ports is the drain phase. In that phase a served device keeps its request asserted while another, eligible request waits. The stimulus holds the served device's request high after its acknowledge, with a lower group also requesting and the boundary strobe high every cycle. It then confirms that no grant appears for several cycles, releases the request, and expects the waiting device next. The timeout path is reached by granting a device the bench never answers. The bench counts the grant cycles and then checks that arbitration recovers.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int PRI_OFFSET = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRANT = 2'd1,
    ST_DRAIN = 2'd2
  } arb_state_e;
endpackage

// File: rtl/irq_chain_pick.sv
// Daisy-chain resolution for one request group: lowest position wins.
module irq_chain_pick #(
  parameter int DEVS = 4,
  localparam int DW = (DEVS > 1) ? $clog2(DEVS) : 1
) (
  input  logic [DEVS-1:0] req_i,
  output logic            any_o,
  output logic [DW-1:0]   first_o
);
  always_comb begin
    first_o = '0;
    for (int i = DEVS - 1; i >= 0; i--) begin
      if (req_i[i]) first_o = DW'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_group_select.sv
// Picks the highest requesting group and its nearest requester.
module irq_group_select #(
  parameter int LINES = 4,
  parameter int DEVS  = 4,
  localparam int NDEV = LINES * DEVS,
  localparam int LW   = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int DW   = (DEVS > 1) ? $clog2(DEVS) : 1
) (
  input  logic [NDEV-1:0] dev_req_i,
  output logic            win_valid_o,
  output logic [LW-1:0]   win_line_o,
  output logic [DW-1:0]   win_dev_o
);
  logic [LINES-1:0] line_any;
  logic [DW-1:0]    line_first [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_chain
    irq_chain_pick #(.DEVS(DEVS)) chain_i (
      .req_i   (dev_req_i[g*DEVS +: DEVS]),
      .any_o   (line_any[g]),
      .first_o (line_first[g])
    );
  end

  always_comb begin
    win_line_o = '0;
    win_dev_o  = '0;
    for (int l = 0; l < LINES; l++) begin
      if (line_any[l]) begin
        win_line_o = LW'(l);
        win_dev_o  = line_first[l];
      end
    end
  end

  assign win_valid_o = |line_any;
endmodule

// File: rtl/irq_bus_arbiter.sv
module irq_bus_arbiter
  import irq_arb_pkg::*;
#(
  parameter int LINES       = 4,
  parameter int DEVS        = 4,
  parameter int VEC_W       = 9,
  parameter int PRI_W       = 3,
  parameter int TIMEOUT_CYC = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LINES*DEVS-1:0] dev_req_i,
  input  logic [PRI_W-1:0]      cpu_pri_i,
  input  logic                  insn_end_i,
  output logic [LINES*DEVS-1:0] dev_gnt_o,
  input  logic                  vec_valid_i,
  input  logic [VEC_W-1:0]      vec_i,
  output logic                  take_o,
  output logic [VEC_W-1:0]      vec_o,
  output logic                  norsp_o
);
  localparam int NDEV = LINES * DEVS;
  localparam int LW   = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int DW   = (DEVS > 1) ? $clog2(DEVS) : 1;
  localparam int IW   = (NDEV > 1) ? $clog2(NDEV) : 1;
  localparam int CW   = $clog2(TIMEOUT_CYC + 1);

  logic          win_valid;
  logic [LW-1:0] win_line;
  logic [DW-1:0] win_dev;
  logic [IW-1:0] win_idx;
  logic          win_ok;

  arb_state_e    state_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] cnt_q;

  irq_group_select #(.LINES(LINES), .DEVS(DEVS)) sel_i (
    .dev_req_i   (dev_req_i),
    .win_valid_o (win_valid),
    .win_line_o  (win_line),
    .win_dev_o   (win_dev)
  );

  assign win_idx = IW'(int'(win_line) * DEVS + int'(win_dev));
  // Strict comparison: equal level keeps the request pending.
  assign win_ok  = win_valid && ((int'(win_line) + PRI_OFFSET) > int'(cpu_pri_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      cnt_q     <= '0;
      dev_gnt_o <= '0;
      take_o    <= 1'b0;
      norsp_o   <= 1'b0;
      vec_o     <= '0;
    end else begin
      take_o  <= 1'b0;
      norsp_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (insn_end_i && win_ok) begin
            dev_gnt_o <= NDEV'(1) << win_idx;
            idx_q     <= win_idx;
            cnt_q     <= '0;
            state_q   <= ST_GRANT;
          end
        end
        ST_GRANT: begin
          if (vec_valid_i) begin
            vec_o     <= vec_i;
            take_o    <= 1'b1;
            dev_gnt_o <= '0;
            state_q   <= ST_DRAIN;
          end else if (cnt_q == CW'(TIMEOUT_CYC - 1)) begin
            norsp_o   <= 1'b1;
            dev_gnt_o <= '0;
            state_q   <= ST_DRAIN;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (!dev_req_i[idx_q]) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_bus_arbiter_chk.sv
module irq_bus_arbiter_chk
  import irq_arb_pkg::*;
#(
  parameter int LINES = 4,
  parameter int DEVS  = 4,
  parameter int VEC_W = 9,
  parameter int PRI_W = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic [LINES*DEVS-1:0] dev_req_i,
  input logic [PRI_W-1:0]      cpu_pri_i,
  input logic                  insn_end_i,
  input logic [LINES*DEVS-1:0] dev_gnt_o,
  input logic                  vec_valid_i,
  input logic [VEC_W-1:0]      vec_i,
  input logic                  take_o,
  input logic [VEC_W-1:0]      vec_o,
  input logic                  norsp_o
);
  localparam int NDEV = LINES * DEVS;

  int  gnt_line;
  logic gnt_any;

  always_comb begin
    gnt_line = 0;
    for (int i = 0; i < NDEV; i++) begin
      if (dev_gnt_o[i]) gnt_line = i / DEVS;
    end
  end
  assign gnt_any = |dev_gnt_o;

  p_one_grant_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_gnt_o));

  p_grant_at_boundary_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_any) |-> $past(insn_end_i));

  p_grant_above_level_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_any) |-> ((gnt_line + PRI_OFFSET) > int'($past(cpu_pri_i))));

  p_grant_highest_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_any) |-> (($past(dev_req_i) >> ((gnt_line + 1) * DEVS)) == '0));

  p_grant_to_requester_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_any) |-> ((dev_gnt_o & $past(dev_req_i)) != '0));

  p_take_after_ack_r6: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ($past(vec_valid_i) && ($past(dev_gnt_o) != '0) && !gnt_any));

  p_vec_capture_r6: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (vec_o == $past(vec_i)));

  p_norsp_clean_r8: assert property (@(posedge clk) disable iff (rst)
    norsp_o |-> (!$past(vec_valid_i) && !gnt_any && !take_o));
endmodule

bind irq_bus_arbiter irq_bus_arbiter_chk #(
  .LINES(LINES), .DEVS(DEVS), .VEC_W(VEC_W), .PRI_W(PRI_W)
) chk_i (.*);

// File: tb/irq_bus_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_bus_arbiter_tb_top;
  localparam int LINES = 4;
  localparam int DEVS  = 4;
  localparam int NDEV  = LINES * DEVS;
  localparam int VEC_W = 9;
  localparam int PRI_W = 3;
  localparam int TMO   = 12;

  typedef struct {
    int    kind;   // 0 grant index, 1 taken vector, 2 no-response
    int    data;
    string tag;
  } sb_item_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NDEV-1:0]  dev_req = '0;
  logic [PRI_W-1:0] cpu_pri = '0;
  logic             insn_end = 1'b0;
  logic [NDEV-1:0]  dev_gnt;
  logic             vec_valid = 1'b0;
  logic [VEC_W-1:0] vec_in = '0;
  logic             take;
  logic [VEC_W-1:0] vec_out;
  logic             norsp;

  int n_cmp = 0;
  int n_bad = 0;
  bit run_mon = 1'b0;
  logic [NDEV-1:0] prev_gnt = '0;
  sb_item_t sb[$];

  always #2.5 clk = ~clk;

  irq_bus_arbiter #(
    .LINES(LINES), .DEVS(DEVS), .VEC_W(VEC_W), .PRI_W(PRI_W), .TIMEOUT_CYC(TMO)
  ) dut_i (
    .clk(clk), .rst(rst), .dev_req_i(dev_req), .cpu_pri_i(cpu_pri),
    .insn_end_i(insn_end), .dev_gnt_o(dev_gnt), .vec_valid_i(vec_valid),
    .vec_i(vec_in), .take_o(take), .vec_o(vec_out), .norsp_o(norsp)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int idx_of(input logic [NDEV-1:0] g);
    int r = -1;
    for (int i = 0; i < NDEV; i++) if (g[i]) r = i;
    return r;
  endfunction

  task automatic expect_ev(input int kind, input int data, input string tag);
    sb_item_t it;
    it.kind = kind; it.data = data; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic observe(input int kind, input int data);
    sb_item_t it;
    if (sb.size() == 0) begin
      chk(1'b0, "R7 unexpected event", kind * 1000 + data, -1);
    end else begin
      it = sb.pop_front();
      chk(it.kind == kind && it.data == data, it.tag,
          kind * 1000 + data, it.kind * 1000 + it.data);
    end
  endtask

  // Monitor: turns output activity into events and compares with the queue.
  always @(negedge clk) begin
    if (run_mon && !rst) begin
      if (dev_gnt != '0 && prev_gnt == '0) observe(0, idx_of(dev_gnt));
      if (take) observe(1, int'(vec_out));
      if (norsp) observe(2, 0);
      chk($countones(dev_gnt) <= 1, "R9 one grant", $countones(dev_gnt), 1);
    end
    prev_gnt = dev_gnt;
  end

  task automatic wait_grant();
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (dev_gnt != '0) break;
    end
  endtask

  // Device side: answer the current grant with a vector.
  task automatic ack_one(input int v, input bit drop, input string tag);
    int g;
    expect_ev(1, v, tag);
    wait_grant();
    g = idx_of(dev_gnt);
    vec_valid = 1'b1;
    vec_in = VEC_W'(v);
    @(negedge clk);
    chk(dev_gnt == '0, "R6 grant drops with take", int'(dev_gnt), 0);
    chk(take == 1'b1, "R6 take pulse", int'(take), 1);
    vec_valid = 1'b0;
    if (drop && g >= 0) dev_req[g] = 1'b0;
    @(negedge clk);
    chk(take == 1'b0, "R6 take one cycle", int'(take), 0);
  endtask

  task automatic no_grant_for(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(dev_gnt == '0, tag, int'(dev_gnt), 0);
    end
  endtask

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    chk(dev_gnt == '0 && !take && !norsp && vec_out == '0, "R1 reset state",
        int'(dev_gnt), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(dev_gnt == '0 && !take && !norsp, "R1 after reset", int'(dev_gnt), 0);
    run_mon = 1'b1;

    // R5: no boundary strobe, no grant
    dev_req[1*DEVS + 0] = 1'b1;
    no_grant_for(5, "R5 held without boundary");
    expect_ev(0, 1*DEVS + 0, "R5 grant at boundary");
    insn_end = 1'b1;
    @(negedge clk);
    chk(dev_gnt[1*DEVS + 0] == 1'b1, "R5 grant next cycle", int'(dev_gnt), 1 << DEVS);
    ack_one(9'h0A4, 1'b1, "R6 vector 0A4");

    // R3: higher group first
    dev_req[1*DEVS + 0] = 1'b1;
    dev_req[3*DEVS + 2] = 1'b1;
    expect_ev(0, 3*DEVS + 2, "R3 highest group");
    ack_one(9'h1F0, 1'b1, "R6 vector 1F0");
    expect_ev(0, 1*DEVS + 0, "R3 lower group after");
    ack_one(9'h024, 1'b1, "R6 vector 024");

    // R4: nearest in chain first
    dev_req[2*DEVS + 3] = 1'b1;
    dev_req[2*DEVS + 1] = 1'b1;
    expect_ev(0, 2*DEVS + 1, "R4 nearest device");
    ack_one(9'h0C8, 1'b1, "R6 vector 0C8");
    expect_ev(0, 2*DEVS + 3, "R4 farther device");
    ack_one(9'h0CC, 1'b1, "R6 vector 0CC");

    // R2: level equal to priority blocks
    cpu_pri = 3'd6;
    dev_req[2*DEVS + 0] = 1'b1;
    no_grant_for(8, "R2 group 2 at level 6 blocked");
    expect_ev(0, 2*DEVS + 0, "R2 granted after level lowered");
    cpu_pri = 3'd5;
    ack_one(9'h100, 1'b1, "R6 vector 100");
    cpu_pri = 3'd7;
    dev_req[3*DEVS + 0] = 1'b1;
    no_grant_for(6, "R2 level 7 blocks all");
    expect_ev(0, 3*DEVS + 0, "R2 group 3 above level 6");
    cpu_pri = 3'd6;
    ack_one(9'h104, 1'b1, "R6 vector 104");
    cpu_pri = 3'd0;

    // R7: served device keeps its request, another waits
    dev_req[1*DEVS + 2] = 1'b1;
    dev_req[0*DEVS + 1] = 1'b1;
    expect_ev(0, 1*DEVS + 2, "R7 first served");
    ack_one(9'h0F0, 1'b0, "R6 vector 0F0");
    no_grant_for(6, "R7 no grant while served device requests");
    dev_req[1*DEVS + 2] = 1'b0;
    expect_ev(0, 0*DEVS + 1, "R7 waiting device after drop");
    ack_one(9'h0F4, 1'b1, "R6 vector 0F4");

    // R8: unanswered grant times out
    dev_req[1*DEVS + 1] = 1'b1;
    expect_ev(0, 1*DEVS + 1, "R8 grant before timeout");
    expect_ev(2, 0, "R8 no-response pulse");
    wait_grant();
    cyc = 0;
    while (dev_gnt != '0 && cyc < 100) begin
      cyc++;
      @(negedge clk);
    end
    chk(cyc == TMO, "R8 grant length", cyc, TMO);
    chk(norsp == 1'b1 && take == 1'b0, "R8 flag on withdraw", int'(norsp), 1);
    dev_req[1*DEVS + 1] = 1'b0;
    @(negedge clk);
    chk(norsp == 1'b0, "R8 flag one cycle", int'(norsp), 0);

    // recovery after timeout
    dev_req[3*DEVS + 3] = 1'b1;
    expect_ev(0, 3*DEVS + 3, "R8 recovery grant");
    ack_one(9'h1FC, 1'b1, "R6 vector 1FC");

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R6 all expected events seen", sb.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule